// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Generator

This block produces the per-line bias-level codes that drive a four-common, 1/3-bias passive LCD panel. A fast input clock is first cut down by a fixed divider into a base tick of roughly 1 kHz. A 4-bit prescaler then stretches that tick into the step clock that paces the common scan. Each common owns a time slot of two steps. One bit of a pixel array selects dark or clear for each segment/common crossing, and a 2-bit code per output line tells the analog driver which of the four bias levels V0..V3 to apply.

Two polarity schemes are available. In type A the drive polarity flips halfway through every common slot, so every pixel nets zero DC inside one frame. In type B the polarity is held for a whole frame and flips at each frame boundary, so the DC balance takes two frames. The pixel array is copied into an internal register at every frame boundary, so a write made partway through a frame never splits a frame. When the enable input is low, every output sits at V0 and the scan restarts from the beginning.

Top module: `lcdw_top`

## Requirements
- R1: While `en` is low, every `com_lvl` and `seg_lvl` code is 0 (V0). After `en` rises, the scan starts again at common 0 in the positive phase, with the frame parity cleared.
- R2: With `en` high, a base tick occurs once every `BASE_DIV` input clocks (8192 by default).
- R3: With prescaler value N (0..15), each step lasts N+1 base ticks. The first step change comes (N+1)*`BASE_DIV` clocks after `en` rises.
- R4: Commons are scanned in order 0,1,..,`NUM_COM`-1 and then wrap. Each common slot is two steps, so a frame is 2*`NUM_COM` steps.
- R5: The active common drives code 3 in the positive phase and code 0 in the negative phase. Every other common drives code 1 in the positive phase and code 2 in the negative phase. Line i uses bits [2i+1:2i] of its bus.
- R6: Pixel bit c*`NUM_SEG`+s belongs to segment s and common c, and 1 means dark. During common c's slot, a dark segment drives code 0 in the positive phase and code 3 in the negative phase. A clear segment drives code 2 in the positive phase and code 1 in the negative phase.
- R7: With `wave_sel`=0 (type A), the first step of each common slot is positive and the second is negative. Every pixel's summed (segment minus common) level over one frame is zero.
- R8: With `wave_sel`=1 (type B), the phase is constant within a frame: positive in the first frame after enable, then alternating every frame. Every pixel's sum is zero over two frames.
- R9: The pixel array is sampled at each frame boundary (and continuously while disabled). A change made mid-frame appears only from the next frame.
- R10: During the active common's slot, a dark pixel sees a level difference of magnitude 3 and a clear pixel a magnitude of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive enable; low forces V0 and restarts the scan |
| wave_sel | input | 1 | Polarity scheme: 0 = type A, 1 = type B |
| presc | input | 4 | Prescaler value N; each step lasts N+1 base ticks |
| pix_data | input | NUM_COM*NUM_SEG | Pixel array, bit c*NUM_SEG+s, 1 = dark |
| com_lvl | output | 2*NUM_COM | Bias-level code per common line |
| seg_lvl | output | 2*NUM_SEG | Bias-level code per segment line |

## Verification
A vector table runs both polarity schemes with sparse, dense, all-dark and single-pixel patterns, at several prescaler values. The sampled step points fall in the positive half, the negative half, the last slot and the second frame. A check on the second-frame step separates type A from type B, because only type B carries the phase across the frame boundary. A pattern that is dark on one common and clear on the next confirms that the row is picked by the active common.

Directed runs sum the level difference of every pixel over one frame in type A and over two frames in type B. These sums expose any unbalanced level choice. A mid-frame data change checks that the pixel array is sampled only at the frame boundary. Sampling one clock before and exactly at the first step edge pins down the divider and prescaler timing.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LV0 = 2'd0;
  localparam lvl_t LV1 = 2'd1;
  localparam lvl_t LV2 = 2'd2;
  localparam lvl_t LV3 = 2'd3;

  typedef enum logic {
    WAVE_A = 1'b0,
    WAVE_B = 1'b1
  } wave_t;

  // level for a common line
  function automatic lvl_t com_drive(input logic active, input logic neg);
    if (active) return neg ? LV0 : LV3;
    return neg ? LV2 : LV1;
  endfunction

  // level for a segment line
  function automatic lvl_t seg_drive(input logic dark, input logic neg);
    if (dark) return neg ? LV3 : LV0;
    return neg ? LV1 : LV2;
  endfunction

  // which half-cycle polarity applies
  function automatic logic phase_neg(input wave_t w, input logic half, input logic par);
    return (w == WAVE_A) ? half : par;
  endfunction

endpackage

// File: rtl/lcdw_clkdiv.sv
module lcdw_clkdiv #(
  parameter int BASE_DIV = 8192,
  parameter int PRE_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  output logic             base_tick,
  output logic             step_tick
);

  localparam int BW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);

  logic [BW-1:0]    base_cnt;
  logic [PRE_W-1:0] pre_cnt;

  assign base_tick = en && (base_cnt == BASE_LAST);
  assign step_tick = base_tick && (pre_cnt >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt <= '0;
      pre_cnt  <= '0;
    end else if (!en) begin
      base_cnt <= '0;
      pre_cnt  <= '0;
    end else begin
      base_cnt <= base_tick ? '0 : base_cnt + 1'b1;
      if (base_tick) pre_cnt <= step_tick ? '0 : pre_cnt + 1'b1;
    end
  end

  // R2
  base_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick)
    else $error("base tick repeated on consecutive clocks");

  // R3
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (pre_cnt == '0))
    else $error("prescaler did not restart after a step");

endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq #(
  parameter int NUM_COM = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic                               step_tick,
  input  lcdw_pkg::wave_t                    wave_sel,
  output logic [$clog2(NUM_COM)-1:0]         com_idx,
  output logic                               neg,
  output logic                               frame_load
);
  import lcdw_pkg::*;

  localparam int CW = $clog2(NUM_COM);
  localparam logic [CW-1:0] COM_LAST = CW'(NUM_COM - 1);

  logic half;
  logic frame_par;
  logic last_step;

  assign last_step  = step_tick && half && (com_idx == COM_LAST);
  assign frame_load = !en || last_step;
  assign neg        = en && phase_neg(wave_sel, half, frame_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half      <= 1'b0;
      frame_par <= 1'b0;
      com_idx   <= '0;
    end else if (!en) begin
      half      <= 1'b0;
      frame_par <= 1'b0;
      com_idx   <= '0;
    end else if (step_tick) begin
      half <= ~half;
      if (half) com_idx <= (com_idx == COM_LAST) ? '0 : com_idx + 1'b1;
      if (last_step) frame_par <= ~frame_par;
    end
  end

  // R1
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (com_idx == '0 && !neg))
    else $error("scan not restarted while disabled");

  // R4
  com_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_tick) |=> (!en || $stable(com_idx)))
    else $error("common advanced without a step");

  // R7
  typea_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wave_sel == WAVE_A && step_tick) |=> (!en || wave_sel != WAVE_A || neg != $past(neg)))
    else $error("type A phase did not flip on a step");

  // R8
  typeb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wave_sel == WAVE_B && !last_step) |=> (!en || wave_sel != WAVE_B || $stable(neg)))
    else $error("type B phase changed inside a frame");

endmodule

// File: rtl/lcdw_drive.sv
module lcdw_drive #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       frame_load,
  input  logic [NUM_COM*NUM_SEG-1:0] pix_data,
  input  logic [$clog2(NUM_COM)-1:0] com_idx,
  input  logic                       neg,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  import lcdw_pkg::*;

  logic [NUM_COM*NUM_SEG-1:0] pix_q;
  logic [NUM_SEG-1:0]         row;
  logic [NUM_COM-1:0]         com_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pix_q <= '0;
    else if (frame_load) pix_q <= pix_data;
  end

  assign row = pix_q[int'(com_idx)*NUM_SEG +: NUM_SEG];

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = en ? com_drive(com_idx == c, neg) : LV0;
    assign com_ext[c] = (com_lvl[2*c +: 2] == LV0) || (com_lvl[2*c +: 2] == LV3);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_lvl[2*s +: 2] = en ? seg_drive(row[s], neg) : LV0;
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_load) |=> $stable(pix_q))
    else $error("pixel copy changed mid-frame");

  // R5
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(com_ext) == 1))
    else $error("not exactly one common at an outer level");

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (com_lvl == '0 && seg_lvl == '0))
    else $error("outputs not at V0 while disabled");

endmodule

// File: rtl/lcdw_top.sv
module lcdw_top #(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 8,
  parameter int BASE_DIV = 8192,
  parameter int PRE_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       wave_sel,
  input  logic [PRE_W-1:0]           presc,
  input  logic [NUM_COM*NUM_SEG-1:0] pix_data,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  import lcdw_pkg::*;

  localparam int CW = $clog2(NUM_COM);

  logic          base_tick;
  logic          step_tick;
  logic          frame_load;
  logic          neg;
  logic [CW-1:0] com_idx;
  wave_t         wave;

  assign wave = wave_t'(wave_sel);

  lcdw_clkdiv #(.BASE_DIV(BASE_DIV), .PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc),
    .base_tick(base_tick), .step_tick(step_tick)
  );

  lcdw_seq #(.NUM_COM(NUM_COM)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .step_tick(step_tick),
    .wave_sel(wave), .com_idx(com_idx), .neg(neg), .frame_load(frame_load)
  );

  lcdw_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_drv (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_load(frame_load),
    .pix_data(pix_data), .com_idx(com_idx), .neg(neg),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // R3
  step_on_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |-> base_tick)
    else $error("step without a base tick");

endmodule

// File: tb/tb_lcdw_top.sv
module tb_lcdw_top;
  localparam int NC = 4;
  localparam int NS = 8;
  localparam int BDIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0;
  logic wave_sel = 0;
  logic [3:0] presc = 0;
  logic [NC*NS-1:0] pix_data = 0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcdw_top #(.NUM_COM(NC), .NUM_SEG(NS), .BASE_DIV(BDIV), .PRE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wave_sel(wave_sel), .presc(presc),
    .pix_data(pix_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // vector: {type, presc[3:0], step[7:0], data[31:0]}
  localparam logic [44:0] VEC [9] = '{
    {1'b0, 4'd0,  8'd0,  32'h0000_00FF},
    {1'b0, 4'd0,  8'd1,  32'hA5A5_5A5A},
    {1'b0, 4'd1,  8'd5,  32'hFFFF_0000},
    {1'b0, 4'd2,  8'd7,  32'h1234_5678},
    {1'b1, 4'd0,  8'd3,  32'h0F0F_F0F0},
    {1'b1, 4'd1,  8'd9,  32'hFFFF_FFFF},
    {1'b1, 4'd0,  8'd12, 32'h0000_0001},
    {1'b0, 4'd15, 8'd10, 32'hDEAD_BEEF},
    {1'b1, 4'd3,  8'd15, 32'h8000_0001}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int neg_of(input int k, input bit t);
    return t ? ((k / (2*NC)) % 2) : (k % 2);
  endfunction

  function automatic logic [2*NC-1:0] ecom(input int k, input bit t);
    logic [2*NC-1:0] r;
    int act = (k / 2) % NC;
    int n = neg_of(k, t);
    for (int c = 0; c < NC; c++) begin
      int v = (c == act) ? 3*(1-n) : 1+n;
      r[2*c +: 2] = v[1:0];
    end
    return r;
  endfunction

  function automatic logic [2*NS-1:0] eseg(input int k, input bit t, input logic [NC*NS-1:0] d);
    logic [2*NS-1:0] r;
    int act = (k / 2) % NC;
    int n = neg_of(k, t);
    for (int s = 0; s < NS; s++) begin
      int v = d[act*NS + s] ? 3*n : 2-n;
      r[2*s +: 2] = v[1:0];
    end
    return r;
  endfunction

  task automatic start(input bit t, input logic [3:0] p, input logic [NC*NS-1:0] d);
    @(negedge clk);
    en = 0; wave_sel = t; presc = p; pix_data = d;
    @(negedge clk);
    en = 1;
    #1;
  endtask

  // DC balance and swing over a number of steps
  task automatic dc_run(input bit t, input int steps, input string rq,
                        output int nonzero, output int swing_bad);
    int sum [NC][NS];
    int dstep = BDIV;
    logic [NC*NS-1:0] d = 32'h3C96_A50F;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) sum[c][s] = 0;
    swing_bad = 0;
    start(t, 4'd0, d);
    for (int k = 0; k < steps; k++) begin
      int act = (k / 2) % NC;
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < NS; s++) begin
          int diff = int'(seg_lvl[2*s +: 2]) - int'(com_lvl[2*c +: 2]);
          sum[c][s] += diff;
          if (c == act) begin
            int mag = (diff < 0) ? -diff : diff;
            if (mag != (d[c*NS + s] ? 3 : 1)) swing_bad++;
          end
        end
      repeat (dstep) @(negedge clk);
      #1;
    end
    nonzero = 0;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) if (sum[c][s] != 0) nonzero++;
  endtask

  initial begin
    int nz;
    int sb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset com", 32'(com_lvl), 32'h0);
    chk("R1 reset seg", 32'(seg_lvl), 32'h0);
    rst_n = 1;

    foreach (VEC[i]) begin
      bit t = VEC[i][44];
      logic [3:0] p = VEC[i][43:40];
      int k = int'(VEC[i][39:32]);
      logic [31:0] d = VEC[i][31:0];
      int dstep = (int'(p) + 1) * BDIV;
      start(t, p, d);
      repeat (k * dstep) @(negedge clk);
      #1;
      // R4 R5 R7 R8 common levels by step
      chk($sformatf("R5 com vec%0d", i), 32'(com_lvl), 32'(ecom(k, t)));
      // R6 segment levels by data
      chk($sformatf("R6 seg vec%0d", i), 32'(seg_lvl), 32'(eseg(k, t, d)));
    end

    // R2 R3 step timing with presc=2
    start(1'b0, 4'd2, 32'h0000_0F00);
    repeat (3*BDIV - 1) @(negedge clk);
    #1;
    chk("R3 before first step", 32'(com_lvl), 32'(ecom(0, 0)));
    @(negedge clk); #1;
    chk("R2 first step edge", 32'(com_lvl), 32'(ecom(1, 0)));

    // R1 mid-run disable and restart
    repeat (5*BDIV) @(negedge clk);
    en = 0; #1;
    chk("R1 disabled com", 32'(com_lvl), 32'h0);
    chk("R1 disabled seg", 32'(seg_lvl), 32'h0);
    @(negedge clk); en = 1; #1;
    chk("R1 restart com", 32'(com_lvl), 32'(ecom(0, 0)));

    // R9 mid-frame data change
    start(1'b0, 4'd0, 32'hFFFF_FFFF);
    repeat (3*BDIV) @(negedge clk);
    pix_data = 32'h0000_0000;
    repeat (BDIV) @(negedge clk);
    #1;
    chk("R9 old data kept", 32'(seg_lvl), 32'(eseg(4, 0, 32'hFFFF_FFFF)));
    repeat (4*BDIV) @(negedge clk);
    #1;
    chk("R9 new data next frame", 32'(seg_lvl), 32'(eseg(8, 0, 32'h0)));

    // R7 type A balance within a frame, R10 swing
    dc_run(1'b0, 2*NC, "R7", nz, sb);
    chk("R7 typeA frame DC", nz, 0);
    chk("R10 swing typeA", sb, 0);
    // R8 type B unbalanced after one frame, balanced after two
    dc_run(1'b1, 2*NC, "R8", nz, sb);
    chk("R8 typeB one frame not balanced", (nz == 0), 0);
    dc_run(1'b1, 4*NC, "R8", nz, sb);
    chk("R8 typeB two frame DC", nz, 0);
    chk("R10 swing typeB", sb, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule